// File: doc/BRIEF.md
# Carry-Multiplexed Ripple Adder

This block adds two unsigned binary operands of a parameterised width together with a single incoming carry. It returns the sum and the carry that leaves the top bit. Each bit position is a small cell that works out both possible results from its two operand bits before the lower carry is known. For a carry of zero the cell needs the exclusive-or and the and of the bits. For a carry of one it needs the exclusive-nor and the or. The carry coming up from the bit below then drives two 2:1 multiplexers. One picks the sum bit and the other picks the carry handed to the next cell.

The cells are chained in carry order. To keep the netlist tidy they are grouped in fixed-size segments, 16 cells per segment by default, so a 64-bit instance is four segments of sixteen. The block is purely combinational, with no clock and no state. It is meant to sit inside a datapath wherever a compact, low-fan-out adder is wanted. Widths of 8, 16, 32 and 64 bits are all valid settings.

Top module: `cbl_adder`

## Requirements
- R1: For every input, {carry_out, sum_out} equals op_a + op_b + carry_in taken as an unsigned (WIDTH+1)-bit number.
- R2: sum_out[0] is op_a[0] XOR op_b[0] when carry_in is 0, and the XNOR of those two bits when carry_in is 1.
- R3: carry_out is 1 whenever op_a[WIDTH-1] and op_b[WIDTH-1] are both 1. It is 0 whenever both are 0, whatever the lower bits and carry_in are.
- R4: A carry travels through every cell and across segment boundaries. All-ones plus zero with carry_in 1 gives sum_out 0 and carry_out 1, and 0xFFFF plus 1 carries into bit 16.
- R5: When op_b is the bitwise complement of op_a, sum_out is all ~carry_in bits and carry_out equals carry_in.
- R6: When both operands are zero, sum_out equals carry_in zero-extended and carry_out is 0.
- R7: The WIDTH parameter may be 8, 16, 32 or 64. R1 holds at each width, and a segment size larger than WIDTH is reduced to WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry selected by the most significant cell |

## Verification
Random operand pairs check the full addition against a reference sum at all four widths. Directed patterns isolate particular paths. All-zero operands show only the carry_in path reaching the sum. All-ones plus zero with carry_in set, and alternating 0101/1010 operands, force a carry through every multiplexer, so any broken link in the chain shows up as a wrong bit. A value of 0xFFFF plus one tests the hand-off between segments, and all-ones plus all-ones tests the carry-generating selection in every cell.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

  // Both candidate outcomes of one bit cell.
  typedef struct packed {
    logic sum_c0;   // sum if lower carry is 0
    logic cy_c0;    // carry if lower carry is 0
    logic sum_c1;   // sum if lower carry is 1
    logic cy_c1;    // carry if lower carry is 1
  } cand_t;

  function automatic cand_t make_cand(input logic x, input logic y);
    cand_t c;
    logic  diff;
    diff     = x ^ y;
    c.sum_c0 = diff;
    c.sum_c1 = ~diff;
    c.cy_c0  = x & y;
    c.cy_c1  = x | y;
    return c;
  endfunction

  function automatic int unsigned clamp_seg(input int unsigned seg, input int unsigned width);
    return (seg > width) ? width : seg;
  endfunction

endpackage

// File: rtl/cbl_cell.sv
module cbl_cell
  import cbl_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic cy_i,
  output logic s_o,
  output logic cy_o
);

  cand_t cand;

  always_comb begin
    cand = make_cand(x_i, y_i);
    s_o  = cy_i ? cand.sum_c1 : cand.sum_c0;
    cy_o = cy_i ? cand.cy_c1  : cand.cy_c0;
  end

endmodule

// File: rtl/cbl_segment.sv
module cbl_segment #(
  parameter int unsigned CELLS = 16
) (
  input  logic [CELLS-1:0] x_i,
  input  logic [CELLS-1:0] y_i,
  input  logic             cy_i,
  output logic [CELLS-1:0] s_o,
  output logic             cy_o
);

  logic [CELLS:0] link;

  assign link[0] = cy_i;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    cbl_cell u_cell (
      .x_i  (x_i[k]),
      .y_i  (y_i[k]),
      .cy_i (link[k]),
      .s_o  (s_o[k]),
      .cy_o (link[k+1])
    );
  end

  assign cy_o = link[CELLS];

endmodule

// File: rtl/cbl_adder.sv
module cbl_adder
  import cbl_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned SEG_W = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  localparam int unsigned SEG  = clamp_seg(SEG_W, WIDTH);
  localparam int unsigned NSEG = WIDTH / SEG;

  logic [NSEG:0] seg_cy;

  assign seg_cy[0] = carry_in;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    cbl_segment #(.CELLS(SEG)) u_seg (
      .x_i  (op_a[g*SEG +: SEG]),
      .y_i  (op_b[g*SEG +: SEG]),
      .cy_i (seg_cy[g]),
      .s_o  (sum_out[g*SEG +: SEG]),
      .cy_o (seg_cy[g+1])
    );
  end

  assign carry_out = seg_cy[NSEG];

endmodule

// File: rtl/cbl_adder_chk.sv
module cbl_adder_chk #(
  parameter int unsigned WIDTH = 64
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out
);

  logic [WIDTH:0] ref_sum;

  always_comb begin
    ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    // R1
    sum_match_chk: assert ({carry_out, sum_out} == ref_sum)
      else $error("R1 sum mismatch");
    // R2
    low_bit_chk: assert (sum_out[0] == (carry_in ? ~(op_a[0] ^ op_b[0]) : (op_a[0] ^ op_b[0])))
      else $error("R2 bit 0 mismatch");
    // R3
    top_carry_chk: assert (!(op_a[WIDTH-1] && op_b[WIDTH-1]) || carry_out)
      else $error("R3 missing carry-out");
    // R3
    top_kill_chk: assert (op_a[WIDTH-1] || op_b[WIDTH-1] || !carry_out)
      else $error("R3 spurious carry-out");
    // R5
    compl_chk: assert ((op_b != ~op_a) || ((sum_out == {WIDTH{~carry_in}}) && (carry_out == carry_in)))
      else $error("R5 complement pair mismatch");
    // R6
    zero_chk: assert ((op_a != '0) || (op_b != '0) ||
                      ((sum_out == {{(WIDTH-1){1'b0}}, carry_in}) && !carry_out))
      else $error("R6 zero operand mismatch");
  end

endmodule

bind cbl_adder cbl_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum_out   (sum_out),
  .carry_out (carry_out)
);

// File: tb/cbl_adder_test.sv
module cbl_adder_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2ns clk = ~clk;   // 250 MHz

  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        ci = 1'b0;

  logic [63:0] s64; logic c64;
  logic [31:0] s32; logic c32;
  logic [15:0] s16; logic c16;
  logic [7:0]  s8;  logic c8;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  cbl_adder #(.WIDTH(64)) uut (
    .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s64), .carry_out(c64));
  cbl_adder #(.WIDTH(32)) uut32 (
    .op_a(a[31:0]), .op_b(b[31:0]), .carry_in(ci), .sum_out(s32), .carry_out(c32));
  cbl_adder #(.WIDTH(16)) uut16 (
    .op_a(a[15:0]), .op_b(b[15:0]), .carry_in(ci), .sum_out(s16), .carry_out(c16));
  cbl_adder #(.WIDTH(8)) uut8 (
    .op_a(a[7:0]), .op_b(b[7:0]), .carry_in(ci), .sum_out(s8), .carry_out(c8));

  function automatic logic [64:0] ref_add(input logic [63:0] x, input logic [63:0] y,
                                          input logic c, input int w);
    logic [64:0] mask;
    logic [64:0] full;
    mask = (65'd1 << w) - 65'd1;
    full = ({1'b0, x} & mask) + ({1'b0, y} & mask) + {64'd0, c};
    return full & ((65'd1 << (w + 1)) - 65'd1);
  endfunction

  task automatic cmp(input string tag, input logic [64:0] got, input logic [64:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " w64"}, {c64, s64},        ref_add(a, b, ci, 64));
    cmp({tag, " w32"}, {32'd0, c32, s32}, ref_add(a, b, ci, 32));
    cmp({tag, " w16"}, {48'd0, c16, s16}, ref_add(a, b, ci, 16));
    cmp({tag, " w8"},  {56'd0, c8, s8},   ref_add(a, b, ci, 8));
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic c);
    @(posedge clk);
    a  = x;
    b  = y;
    ci = c;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero inputs give zero result (R6)
    cmp("R6 reset zero", {c64, s64}, 65'd0);

    apply('0, '0, 1'b1);
    check_all("R6 zero cin1");
    cmp("R6 sum equals cin", {c64, s64}, 65'd1);

    apply('1, '1, 1'b0);
    check_all("R3 ones+ones");
    cmp("R3 carry generate", {64'd0, c64}, 65'd1);

    apply('1, '0, 1'b1);
    check_all("R4 full ripple");
    cmp("R4 ripple to top", {c64, s64}, {1'b1, 64'd0});

    apply(64'h0000_0000_0000_FFFF, 64'd1, 1'b0);
    check_all("R4 segment hop");
    cmp("R4 bit16 set", {c64, s64}, 65'h1_0000);

    apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0);
    check_all("R5 alt cin0");
    cmp("R5 all ones", {c64, s64}, {1'b0, {64{1'b1}}});

    apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1);
    check_all("R5 alt cin1");
    cmp("R5 wrap to zero", {c64, s64}, {1'b1, 64'd0});

    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    cmp("R3 msb pair", {64'd0, c64}, 65'd1);

    apply(64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
    cmp("R3 msb clear", {64'd0, c64}, 65'd0);

    for (int k = 0; k < 4; k++) begin
      apply({63'd0, k[0]}, {63'd0, k[1]}, 1'b0);
      cmp("R2 bit0 cin0", {64'd0, s64[0]}, {64'd0, k[0] ^ k[1]});
      apply({63'd0, k[0]}, {63'd0, k[1]}, 1'b1);
      cmp("R2 bit0 cin1", {64'd0, s64[0]}, {64'd0, ~(k[0] ^ k[1])});
    end

    for (int n = 0; n < 3000; n++) begin
      apply({$urandom(), $urandom()}, {$urandom(), $urandom()}, 1'($urandom()));
      check_all("R1 R7 random");
    end

    finish_run();
  end

endmodule